// File: doc/BRIEF.md
# SPI Octal DAC Command Driver

This block is a transmit-only SPI master for an eight-channel, 12-bit digital-to-analog converter. A requester offers a command code, a channel address, a sample value and a configuration byte. The offer is made on a valid/ready stream port. The block latches all four fields into a single 32-bit word and shifts that word out most significant bit first on a serial clock, a data line and an active-low chip select. The block checks no command or address code. Reserved codes go onto the wire exactly as they were given.

The serial clock rate comes from two parameters: the system clock frequency and the requested serial clock frequency. The requested rate is limited to 50 MHz. The serial clock rests high while chip select is high. Data changes on falling serial clock edges, so it is steady at each rising edge, where the converter samples it.

Back-pressure rules are as follows. An offer is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. After that edge, `req_ready_o` stays low until the word has been sent and a guard interval has passed. The requester may change or withdraw its fields at any time while `req_ready_o` is low. If `req_valid_i` is still high when `req_ready_o` returns high, the fields present at that moment are accepted at once.

Top module: `octdac_spi_tx`

## Requirements
- R1: After reset, and whenever idle, `req_ready_o`=1, `spi_cs_no`=1, `spi_sclk_o`=1 and `spi_mosi_o`=0.
- R2: An edge with `req_valid_i`=1 and `req_ready_o`=1 accepts the offer. In the following cycle both `req_ready_o` and `spi_cs_no` are 0.
- R3: While `req_valid_i` is 0 and the block is idle, no transfer starts: `req_ready_o` and `spi_cs_no` stay 1.
- R4: Each transfer sends exactly 32 bits, most significant first. Bits [31:28] are 0. Bits [27:24] carry the command, bits [23:20] the address, bits [19:8] the sample and bits [7:0] the configuration. Every command value from 0 to 15 and every address value from 0 to 15 is sent unchanged. Address 15 means all channels; command 8 sets up the reference.
- R5: While chip select is low, `spi_mosi_o` changes only together with a falling `spi_sclk_o` edge, or in the cycle chip select falls. It never changes while `spi_sclk_o` stays high.
- R6: Let H = max(1, SYS_CLK_HZ / (2 × min(SCLK_HZ, 50 MHz))), which is 5 with the default parameters. Each `spi_sclk_o` level inside a frame lasts H system cycles. The first fall comes H cycles after chip select falls. Chip select is low for 65·H cycles. `spi_sclk_o` is high whenever chip select is high.
- R7: Fields are captured on the accept edge. Changing the inputs afterwards has no effect on the word in flight.
- R8: `req_ready_o` returns to 1 exactly 67·H cycles after the accept edge. This is at least one serial clock period after chip select rises.
- R9: If `req_valid_i` is held high, frames follow one another without gaps in the handshake. Each frame carries the fields present when it was accepted. Chip select stays high for at least 2·H cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Offer of a new command word |
| req_ready_o | output | 1 | High when an offer can be taken |
| req_cmd_i | input | 4 | Converter command code |
| req_chan_i | input | 4 | Channel address (0-7 single channel, 15 all) |
| req_sample_i | input | 12 | Sample value for the converter |
| req_cfg_i | input | 8 | Configuration bits |
| spi_sclk_o | output | 1 | Serial clock, resting high |
| spi_mosi_o | output | 1 | Serial data to the converter |
| spi_cs_no | output | 1 | Chip select, active low |

## Verification
The assertions check several properties on every cycle. Chip select and ready are never high and low at the same time in the wrong combination. The serial clock rests high outside frames. Data never moves while the serial clock is high. An accepted offer drops ready and chip select in the next cycle. Ready rises only after chip select has gone high. The bench alone shows the parts that need a whole frame or a time window: the bit order and field placement of the word, the exact half-period and frame lengths, the immunity of a word in flight to input changes, and the fresh capture and guard interval when offers are held back to back.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

  localparam int unsigned PAD_W    = 4;
  localparam int unsigned CMD_W    = 4;
  localparam int unsigned CHAN_W   = 4;
  localparam int unsigned SAMPLE_W = 12;
  localparam int unsigned CFG_W    = 8;
  localparam int unsigned FRAME_W  = PAD_W + CMD_W + CHAN_W + SAMPLE_W + CFG_W;

  // Highest serial clock rate the converter link tolerates
  localparam int unsigned SCLK_MAX_HZ = 50_000_000;

  // Command codes understood by the converter (others are passed through)
  localparam logic [CMD_W-1:0] CMD_LOAD_INPUT   = 4'h0;
  localparam logic [CMD_W-1:0] CMD_PUSH_OUTPUT  = 4'h1;
  localparam logic [CMD_W-1:0] CMD_LOAD_ALL_UPD = 4'h2;
  localparam logic [CMD_W-1:0] CMD_LOAD_UPD     = 4'h3;
  localparam logic [CMD_W-1:0] CMD_POWER        = 4'h4;
  localparam logic [CMD_W-1:0] CMD_CLEAR_CODE   = 4'h5;
  localparam logic [CMD_W-1:0] CMD_LOAD_MASK    = 4'h6;
  localparam logic [CMD_W-1:0] CMD_SOFT_RESET   = 4'h7;
  localparam logic [CMD_W-1:0] CMD_REFERENCE    = 4'h8;

  // Channel address meaning every channel at once
  localparam logic [CHAN_W-1:0] CHAN_BROADCAST = 4'hF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP
  } tx_state_e;

  typedef struct packed {
    logic [PAD_W-1:0]    pad;
    logic [CMD_W-1:0]    cmd;
    logic [CHAN_W-1:0]   chan;
    logic [SAMPLE_W-1:0] sample;
    logic [CFG_W-1:0]    cfg;
  } frame_t;

  function automatic frame_t build_frame(
    input logic [CMD_W-1:0]    cmd,
    input logic [CHAN_W-1:0]   chan,
    input logic [SAMPLE_W-1:0] sample,
    input logic [CFG_W-1:0]    cfg
  );
    frame_t f;
    f.pad    = '0;
    f.cmd    = cmd;
    f.chan   = chan;
    f.sample = sample;
    f.cfg    = cfg;
    return f;
  endfunction

endpackage

// File: rtl/octdac_halfdiv.sv
// Produces one tick every HALF_DIV system cycles while run_i is high.
module octdac_halfdiv #(
  parameter int unsigned HALF_DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  generate
    if (HALF_DIV <= 1) begin : g_every_cycle
      assign tick_o = run_i;
    end else begin : g_counter
      localparam int unsigned CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (!run_i) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick_o = run_i && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/octdac_shreg.sv
// Parallel-load shift register, MSB leaves first.
module octdac_shreg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             shift_i,
  input  logic             clear_i,
  output logic             bit_o
);

  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= word_i;
    end else if (clear_i) begin
      sr_q <= '0;
    end else if (shift_i) begin
      sr_q <= {sr_q[WIDTH-2:0], 1'b0};
    end
  end

  assign bit_o = sr_q[WIDTH-1];

endmodule

// File: rtl/octdac_ctrl.sv
// Frame sequencer: chip select, serial clock phase, shift and guard timing.
module octdac_ctrl
  import octdac_pkg::*;
#(
  parameter int unsigned NBITS     = 32,
  parameter int unsigned GAP_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic tick_i,
  output logic ready_o,
  output logic run_o,
  output logic load_o,
  output logic shift_o,
  output logic clear_o,
  output logic sclk_o,
  output logic cs_no
);

  localparam int unsigned EDGES = 2 * NBITS;
  localparam int unsigned EW    = $clog2(EDGES + 1);
  localparam int unsigned GW    = $clog2(GAP_TICKS) + 1;
  localparam logic [EW-1:0] EDGE_END = EW'(EDGES);
  localparam logic [GW-1:0] GAP_END  = GW'(GAP_TICKS - 1);

  tx_state_e     state_q;
  logic [EW-1:0] edge_q;
  logic [GW-1:0] gap_q;
  logic          sclk_q;
  logic          cs_nq;
  logic          in_shift;
  logic          at_end;

  assign in_shift = (state_q == ST_SHIFT);
  assign at_end   = (edge_q == EDGE_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      gap_q   <= '0;
      sclk_q  <= 1'b1;
      cs_nq   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (valid_i) begin
            state_q <= ST_SHIFT;
            cs_nq   <= 1'b0;
            edge_q  <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick_i) begin
            if (at_end) begin
              cs_nq   <= 1'b1;
              sclk_q  <= 1'b1;
              gap_q   <= '0;
              state_q <= ST_GAP;
            end else begin
              sclk_q <= ~sclk_q;
              edge_q <= edge_q + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (tick_i) begin
            if (gap_q == GAP_END) begin
              state_q <= ST_IDLE;
            end else begin
              gap_q <= gap_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ready_o = (state_q == ST_IDLE);
    run_o   = (state_q != ST_IDLE);
    load_o  = ready_o && valid_i;
    // Even-numbered edges are falling; edge 0 keeps the first bit in place
    shift_o = in_shift && tick_i && !at_end && !edge_q[0] && (edge_q != '0);
    clear_o = in_shift && tick_i && at_end;
    sclk_o  = sclk_q;
    cs_no   = cs_nq;
  end

endmodule

// File: rtl/octdac_spi_tx.sv
module octdac_spi_tx
  import octdac_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ        = 100_000_000,
  parameter int unsigned SCLK_HZ           = 10_000_000,
  parameter int unsigned IDLE_HALF_PERIODS = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [3:0]  req_cmd_i,
  input  logic [3:0]  req_chan_i,
  input  logic [11:0] req_sample_i,
  input  logic [7:0]  req_cfg_i,
  output logic        spi_sclk_o,
  output logic        spi_mosi_o,
  output logic        spi_cs_no
);

  localparam int unsigned SCLK_EFF  = (SCLK_HZ == 0) ? 1 :
                                      ((SCLK_HZ > SCLK_MAX_HZ) ? SCLK_MAX_HZ : SCLK_HZ);
  localparam int unsigned HALF_RAW  = SYS_CLK_HZ / (2 * SCLK_EFF);
  localparam int unsigned HALF_DIV  = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int unsigned GAP_TICKS = (IDLE_HALF_PERIODS < 2) ? 2 : IDLE_HALF_PERIODS;

  logic   run, tick, load, shift, clear;
  frame_t word;

  assign word = build_frame(req_cmd_i, req_chan_i, req_sample_i, req_cfg_i);

  octdac_halfdiv #(
    .HALF_DIV (HALF_DIV)
  ) i_halfdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  octdac_ctrl #(
    .NBITS     (FRAME_W),
    .GAP_TICKS (GAP_TICKS)
  ) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .tick_i  (tick),
    .ready_o (req_ready_o),
    .run_o   (run),
    .load_o  (load),
    .shift_o (shift),
    .clear_o (clear),
    .sclk_o  (spi_sclk_o),
    .cs_no   (spi_cs_no)
  );

  octdac_shreg #(
    .WIDTH (FRAME_W)
  ) i_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .word_i  (word),
    .shift_i (shift),
    .clear_i (clear),
    .bit_o   (spi_mosi_o)
  );

endmodule

// File: rtl/octdac_spi_tx_chk.sv
module octdac_spi_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic spi_sclk_o,
  input logic spi_mosi_o,
  input logic spi_cs_no
);

  AST_IDLE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> spi_cs_no); // R1

  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && !spi_cs_no)); // R2

  AST_NO_SPURIOUS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && req_ready_o) |=> (req_ready_o && spi_cs_no)); // R3

  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spi_cs_no && $past(!spi_cs_no) && spi_sclk_o && $past(spi_sclk_o))
      |-> $stable(spi_mosi_o)); // R5

  AST_SCLK_REST_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> spi_sclk_o); // R6

  AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_cs_no |-> !req_ready_o); // R8

  AST_READY_AFTER_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> (spi_cs_no && $past(spi_cs_no))); // R8

endmodule

bind octdac_spi_tx octdac_spi_tx_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .spi_sclk_o  (spi_sclk_o),
  .spi_mosi_o  (spi_mosi_o),
  .spi_cs_no   (spi_cs_no)
);

// File: tb/test_octdac_spi_tx.sv
module test_octdac_spi_tx;

  localparam int H = 5;  // 100 MHz / (2 * 10 MHz)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  cmd = '0;
  logic [3:0]  chan = '0;
  logic [11:0] sample = '0;
  logic [7:0]  cfg = '0;
  logic        ready, sclk, mosi, cs_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  octdac_spi_tx i_octdac_spi_tx (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (valid),
    .req_ready_o  (ready),
    .req_cmd_i    (cmd),
    .req_chan_i   (chan),
    .req_sample_i (sample),
    .req_cfg_i    (cfg),
    .spi_sclk_o   (sclk),
    .spi_mosi_o   (mosi),
    .spi_cs_no    (cs_n)
  );

  function automatic logic [31:0] expect_word(logic [3:0] c, logic [3:0] a,
                                              logic [11:0] s, logic [7:0] g);
    return {4'h0, c, a, s, g};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- line monitor ----------------
  logic [31:0] got_word[$];
  int          got_bits[$];
  int          got_low[$];
  int          got_gap[$];
  logic [31:0] rx;
  int nbits, low_cnt, gap_cnt, since;
  int mosi_bad = 0, half_bad = 0, idle_bad = 0, frames = 0;
  logic p_sclk = 1'b1, p_cs = 1'b1, p_mosi = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n) begin
        if (p_cs) begin
          rx = '0; nbits = 0; low_cnt = 1; since = 1;
          if (frames > 0) got_gap.push_back(gap_cnt);
        end else begin
          low_cnt++;
          if (sclk && !p_sclk) begin
            rx = {rx[30:0], mosi};
            nbits++;
          end
          if (sclk && p_sclk && mosi != p_mosi) mosi_bad++;
          if (sclk != p_sclk) begin
            if (since != H) half_bad++;
            since = 1;
          end else begin
            since++;
          end
        end
      end else begin
        if (!sclk) idle_bad++;
        if (!p_cs) begin
          got_word.push_back(rx);
          got_bits.push_back(nbits);
          got_low.push_back(low_cnt);
          frames++;
          gap_cnt = 1;
        end else begin
          gap_cnt++;
        end
      end
      p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
    end
  end

  // Offer one word; optionally disturb inputs after acceptance; wait for ready.
  task automatic send(input logic [3:0] c, input logic [3:0] a,
                      input logic [11:0] s, input logic [7:0] g, input bit disturb);
    int busy;
    logic [31:0] exp_w;
    exp_w = expect_word(c, a, s, g);
    @(negedge clk);
    cmd = c; chan = a; sample = s; cfg = g; valid = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    chk(!ready && !cs_n, "R2 accept", {ready, cs_n}, 2'b00);
    valid = 1'b0;
    busy = 1;
    if (disturb) begin
      cmd = ~c; chan = ~a; sample = ~s; cfg = ~g;
    end
    while (!ready) begin
      @(negedge clk);
      if (!ready) busy++;
      if (disturb && busy == 100) begin
        cmd = $urandom; chan = $urandom; sample = $urandom; cfg = $urandom;
      end
    end
    chk(busy == 67 * H, "R8 ready low cycles", busy, 67 * H);
    chk(got_word.size() > 0, "R4 frame seen", got_word.size(), 1);
    if (got_word.size() > 0) begin
      logic [31:0] w;
      int b, l;
      w = got_word.pop_front(); b = got_bits.pop_front(); l = got_low.pop_front();
      chk(w == exp_w, disturb ? "R7 word after input change" : "R4 word", w, exp_w);
      chk(b == 32, "R4 bit count", b, 32);
      chk(l == 65 * H, "R6 select low cycles", l, 65 * H);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1 ready in reset", ready, 1);
    chk(cs_n == 1'b1, "R1 select in reset", cs_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready && cs_n && sclk && !mosi, "R1 idle outputs",
        {ready, cs_n, sclk, mosi}, 4'b1110);

    // R3: no offer, nothing happens
    begin
      int bad = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (!ready || !cs_n) bad++;
      end
      chk(bad == 0 && frames == 0, "R3 idle without valid", bad, 0);
    end

    // Directed corner words
    send(4'h8, 4'h0, 12'h000, 8'h01, 1'b0);   // R4 reference setup
    send(4'hF, 4'h2, 12'h123, 8'h00, 1'b0);   // R4 reserved command
    send(4'h9, 4'hF, 12'h765, 8'h00, 1'b0);   // R4 broadcast address
    send(4'hF, 4'hF, 12'hFFF, 8'hFF, 1'b0);   // R4 all ones
    send(4'h0, 4'h0, 12'h000, 8'h00, 1'b0);   // R4 all zeros
    send(4'h3, 4'h7, 12'hA5C, 8'h3C, 1'b1);   // R7 inputs change in flight

    // Random words, some disturbed
    for (int i = 0; i < 16; i++) begin
      send(4'($urandom), 4'($urandom), 12'($urandom), 8'($urandom), 1'($urandom));
    end

    // R9: valid held across two frames, second word captured fresh
    begin
      logic [31:0] wa, wb;
      @(negedge clk);
      cmd = 4'h2; chan = 4'h5; sample = 12'h3E1; cfg = 8'h81; valid = 1'b1;
      while (!ready) @(negedge clk);
      @(negedge clk);
      cmd = 4'h1; chan = 4'h6; sample = 12'hC07; cfg = 8'h5A;
      while (!ready) @(negedge clk);
      @(negedge clk);
      chk(!ready && !cs_n, "R9 immediate second accept", {ready, cs_n}, 2'b00);
      valid = 1'b0;
      while (!ready) @(negedge clk);
      chk(got_word.size() == 2, "R9 two frames", got_word.size(), 2);
      if (got_word.size() == 2) begin
        wa = got_word.pop_front(); wb = got_word.pop_front();
        chk(wa == expect_word(4'h2, 4'h5, 12'h3E1, 8'h81), "R9 first word", wa,
            expect_word(4'h2, 4'h5, 12'h3E1, 8'h81));
        chk(wb == expect_word(4'h1, 4'h6, 12'hC07, 8'h5A), "R9 second word", wb,
            expect_word(4'h1, 4'h6, 12'hC07, 8'h5A));
      end
      got_bits.delete(); got_low.delete();
    end

    begin
      int min_gap = 1 << 30;
      foreach (got_gap[i]) if (got_gap[i] < min_gap) min_gap = got_gap[i];
      chk(got_gap.size() > 0 && min_gap >= 2 * H, "R9 select high gap", min_gap, 2 * H);
    end
    chk(mosi_bad == 0, "R5 data steady while clock high", mosi_bad, 0);
    chk(half_bad == 0, "R6 half period length", half_bad, 0);
    chk(idle_bad == 0, "R6 clock rests high", idle_bad, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule